// File: doc/BRIEF.md
# UART Receive Byte Queue with Fill Threshold and Idle Timeout

This block holds the bytes a UART receiver has assembled until the host fetches them. It keeps a small circular byte store with its own count, flags when the store is empty or completely full, raises a threshold status once enough bytes are waiting, and reports an overrun event when a byte is lost because no room is left. A one-shot idle timer produces an event when no further byte has been accepted for four character times. The host uses this event to collect a short tail of data that never reaches the threshold.

The byte source depends on the channel mode. In normal and echo modes the bytes come from the deserializer. In local loopback the host's own data-register writes are looped into the queue. In remote loopback nothing is queued. A detected line break always queues a zero byte. A receive enable and a receive disable gate all queue traffic. A flush control empties the queue at once. The deserializer, the interrupt combiner and the register decode sit outside the block. The character time arrives already converted to clock cycles.

Top module: `uart_rx_buffer`

## Requirements
- R1: The queue holds up to DEPTH (default 16) bytes. Exactly DEPTH bytes can be accepted before it refuses further bytes.
- R2: Bytes leave in the order they were accepted. rd_data shows the popped byte from the cycle after the clock edge that sampled host_rd.
- R3: A byte offered while the count is DEPTH is discarded and the stored contents are untouched. ev_overrun is high for exactly the cycle after that edge.
- R4: st_full is 1 exactly when the count is DEPTH. It is set by the push that reaches DEPTH and is cleared by any enabled host read.
- R5: st_empty is 1 out of reset, after the last byte is read, and after a read of an empty queue. Such a read returns 8'h00. Any accepted push clears st_empty.
- R6: st_trig is set by an accepted push that leaves the count greater than or equal to trig_lvl. It is cleared by an enabled read that leaves the count below trig_lvl and is otherwise held. A trig_lvl above DEPTH (32 is the customary reset value) never sets it.
- R7: ev_timeout is high for one cycle exactly 4*char_clks clock edges after the edge that accepted the most recent byte. Each accepted push restarts the count. A discarded byte does not restart it. char_clks = 0 means no event.
- R8: Pushes and reads act only while rx_en = 1 and rx_dis = 0. Otherwise count, flags and contents are unchanged and a read returns 8'h00.
- R9: flush = 1 forces count 0, st_empty 1, st_full 0, st_trig 0 and cancels the idle timer. It takes priority over a same-cycle push or read, and that read returns 8'h00.
- R10: chan_mode selects the source: 2'd0 (normal) and 2'd1 (echo) take ser_byte on ser_valid, 2'd2 (local loopback) takes host_wdata on host_wr, and 2'd3 (remote loopback) takes neither.
- R11: brk_det queues 8'h00 in every channel mode. At most one byte is queued per cycle, with priority break, then serial input, then host write.
- R12: After reset st_empty = 1, while st_full, st_trig, ev_overrun, ev_timeout and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_byte | input | DATA_W | Byte from the deserializer |
| ser_valid | input | 1 | ser_byte is valid this cycle |
| brk_det | input | 1 | Line break detected, queue a zero byte |
| host_wr | input | 1 | Host write to the data register |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read of the data register |
| trig_lvl | input | TRIG_W | Fill threshold for st_trig |
| char_clks | input | CHAR_W | One character time in clock cycles |
| chan_mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loop, 3 remote loop |
| flush | input | 1 | Empty the queue |
| rx_en | input | 1 | Receive enable |
| rx_dis | input | 1 | Receive disable, overrides rx_en |
| rd_data | output | DATA_W | Registered read data |
| st_empty | output | 1 | Queue empty status |
| st_full | output | 1 | Queue full status |
| st_trig | output | 1 | Fill threshold reached status |
| ev_overrun | output | 1 | One-cycle overrun event |
| ev_timeout | output | 1 | One-cycle idle timeout event |

## Verification
The bench sweeps every threshold from 0 to DEPTH+1, plus 32. In each pass it fills past capacity and then drains past empty. A design with an off-by-one compare would set or clear st_trig one byte early or late. One that stores the overflowing byte would return it on a later read instead of dropping it. One that treats an empty read as a pop would return stale data rather than zero. The bench also crosses all four channel modes with every mix of serial, host and break input, and all four enable combinations with pushes and reads. A wrong source select, a lost break byte, or a read that advances while disabled each show up at rd_data. The idle timer is checked with back-to-back restarts, with a byte dropped on a full queue and with a flush pending. A timer restarted by the dropped byte, or left running by the flush, produces a late or spurious ev_timeout.

// File: rtl/rxbuf_pkg.sv
`timescale 1ns/1ps
package rxbuf_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;
endpackage

// File: rtl/rxbuf_src_sel.sv
`timescale 1ns/1ps
module rxbuf_src_sel
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  chan_mode_e          mode,
  input  logic                ser_valid,
  input  logic [DATA_W-1:0]   ser_byte,
  input  logic                brk_det,
  input  logic                host_wr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic                push_req,
  output logic [DATA_W-1:0]   push_byte
);
  logic ser_take, host_take;

  always_comb begin
    ser_take  = ser_valid && (mode == CH_NORMAL || mode == CH_ECHO);
    host_take = host_wr && (mode == CH_LOCAL);
    push_req  = brk_det || ser_take || host_take;
    if (brk_det)       push_byte = '0;
    else if (ser_take) push_byte = ser_byte;
    else               push_byte = host_wdata;
  end
endmodule

// File: rtl/rxbuf_mem.sv
`timescale 1ns/1ps
module rxbuf_mem #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rzero,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rzero ? '0 : store[raddr];
  end
endmodule

// File: rtl/rxbuf_ctrl.sv
`timescale 1ns/1ps
module rxbuf_ctrl #(
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 6,
  parameter int AW     = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              en,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [TRIG_W-1:0] trig_lvl,
  output logic              push_acc,
  output logic              pop_do,
  output logic [AW-1:0]     wptr,
  output logic [AW-1:0]     rptr,
  output logic              empty_q,
  output logic              full_q,
  output logic              trig_q,
  output logic              ovr_q
);
  localparam int CMP_W = (TRIG_W > CNT_W) ? TRIG_W : CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    PTR_MAX = AW'(DEPTH-1);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CMP_W-1:0] cnt_x, trig_x;
  logic is_full, rd_try, ovr_c;

  always_comb begin
    is_full  = (cnt == CNT_MAX);
    rd_try   = !flush && en && pop_req;
    push_acc = !flush && en && push_req && !is_full;
    ovr_c    = !flush && en && push_req && is_full;
    pop_do   = rd_try && (cnt != '0);
    cnt_n    = cnt;
    if (push_acc) cnt_n = cnt_n + 1'b1;
    if (pop_do)   cnt_n = cnt_n - 1'b1;
    cnt_x    = CMP_W'(cnt_n);
    trig_x   = CMP_W'(trig_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      trig_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (push_acc) wptr <= (wptr == PTR_MAX) ? '0 : wptr + 1'b1;
      if (pop_do)   rptr <= (rptr == PTR_MAX) ? '0 : rptr + 1'b1;
      cnt     <= cnt_n;
      empty_q <= (cnt_n == '0);
      full_q  <= (cnt_n == CNT_MAX);
      ovr_q   <= ovr_c;
      if (push_acc && cnt_x >= trig_x)    trig_q <= 1'b1;
      else if (rd_try && cnt_x < trig_x)  trig_q <= 1'b0;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  p_ovr_no_growth_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !flush && push_req && is_full) |=> (cnt <= $past(cnt)));
  p_full_matches_r4: assert property (@(posedge clk) disable iff (rst)
    full_q == (cnt == CNT_MAX));
  p_empty_matches_r5: assert property (@(posedge clk) disable iff (rst)
    empty_q == (cnt == '0));
  p_trig_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_q) |-> $past(push_acc));
  p_disabled_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!en && !flush) |=> $stable(cnt) && $stable(rptr) && $stable(wptr));
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0) && empty_q && !full_q && !trig_q);
endmodule

// File: rtl/rxbuf_timeout.sv
`timescale 1ns/1ps
module rxbuf_timeout #(
  parameter int CHAR_W = 16,
  parameter int TW     = CHAR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic [CHAR_W-1:0] char_clks,
  output logic              ev_timeout
);
  logic [TW-1:0] tmr;
  logic [TW-1:0] span;

  always_comb span = {char_clks, 2'b00};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      tmr        <= '0;
      ev_timeout <= 1'b0;
    end else begin
      ev_timeout <= (tmr == TW'(1)) && !load;
      if (load)            tmr <= span;
      else if (tmr != '0)  tmr <= tmr - 1'b1;
    end
  end

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ev_timeout |=> !ev_timeout);
  p_reload_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !flush) |=> !ev_timeout);
  p_flush_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tmr == '0) && !ev_timeout);
endmodule

// File: rtl/uart_rx_buffer.sv
`timescale 1ns/1ps
module uart_rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TRIG_W = 6,
  parameter int CHAR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ser_byte,
  input  logic              ser_valid,
  input  logic              brk_det,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic [TRIG_W-1:0] trig_lvl,
  input  logic [CHAR_W-1:0] char_clks,
  input  logic [1:0]        chan_mode,
  input  logic              flush,
  input  logic              rx_en,
  input  logic              rx_dis,
  output logic [DATA_W-1:0] rd_data,
  output logic              st_empty,
  output logic              st_full,
  output logic              st_trig,
  output logic              ev_overrun,
  output logic              ev_timeout
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  chan_mode_e        mode;
  logic              en;
  logic              push_req, push_acc, pop_do;
  logic [DATA_W-1:0] push_byte;
  logic [AW-1:0]     wptr, rptr;

  always_comb begin
    mode = chan_mode_e'(chan_mode);
    en   = rx_en && !rx_dis;
  end

  rxbuf_src_sel #(.DATA_W(DATA_W)) u_sel (
    .mode(mode), .ser_valid(ser_valid), .ser_byte(ser_byte),
    .brk_det(brk_det), .host_wr(host_wr), .host_wdata(host_wdata),
    .push_req(push_req), .push_byte(push_byte)
  );

  rxbuf_ctrl #(.DEPTH(DEPTH), .TRIG_W(TRIG_W), .AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .en(en),
    .push_req(push_req), .pop_req(host_rd), .trig_lvl(trig_lvl),
    .push_acc(push_acc), .pop_do(pop_do), .wptr(wptr), .rptr(rptr),
    .empty_q(st_empty), .full_q(st_full), .trig_q(st_trig), .ovr_q(ev_overrun)
  );

  rxbuf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(push_acc), .waddr(wptr), .wdata(push_byte),
    .re(host_rd), .rzero(!pop_do), .raddr(rptr), .rdata(rd_data)
  );

  rxbuf_timeout #(.CHAR_W(CHAR_W)) u_tmo (
    .clk(clk), .rst(rst), .flush(flush), .load(push_acc),
    .char_clks(char_clks), .ev_timeout(ev_timeout)
  );

  p_remote_no_serial_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_REMOTE && !brk_det) |-> !push_acc);
  p_break_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (brk_det && push_acc) |-> (push_byte == '0));
  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (host_rd && st_empty && !push_acc) |=> (rd_data == '0));
endmodule

// File: tb/uart_rx_buffer_tb_top.sv
`timescale 1ns/1ps
module uart_rx_buffer_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ser_byte = '0;
  logic        ser_valid = 1'b0;
  logic        brk_det = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [5:0]  trig_lvl = 6'd32;
  logic [15:0] char_clks = 16'd1;
  logic [1:0]  chan_mode = 2'd0;
  logic        flush = 1'b0;
  logic        rx_en = 1'b1;
  logic        rx_dis = 1'b0;
  logic [7:0]  rd_data;
  logic        st_empty, st_full, st_trig, ev_overrun, ev_timeout;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  string phase = "R1";

  logic [7:0] mq[$];
  logic [7:0] mrd = '0;
  logic       mtrig = 1'b0;
  int         tleft = 0;

  always #2 clk = ~clk;

  uart_rx_buffer dut_i (
    .clk(clk), .rst(rst), .ser_byte(ser_byte), .ser_valid(ser_valid),
    .brk_det(brk_det), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .trig_lvl(trig_lvl), .char_clks(char_clks),
    .chan_mode(chan_mode), .flush(flush), .rx_en(rx_en), .rx_dis(rx_dis),
    .rd_data(rd_data), .st_empty(st_empty), .st_full(st_full),
    .st_trig(st_trig), .ev_overrun(ev_overrun), .ev_timeout(ev_timeout)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock cycle of stimulus, reference update and output comparison.
  task automatic cyc(input logic sv, input logic [7:0] sb, input logic bk,
                     input logic hw, input logic [7:0] hd, input logic rd);
    logic en, req, acc, wasfull, exp_ovr, exp_to;
    logic [7:0] b;
    int n;
    @(negedge clk);
    ser_valid = sv; ser_byte = sb; brk_det = bk;
    host_wr = hw; host_wdata = hd; host_rd = rd;
    @(posedge clk);
    #1;
    en = rx_en && !rx_dis;
    exp_ovr = 1'b0; exp_to = 1'b0; acc = 1'b0;
    if (rd) mrd = (!flush && en && mq.size() > 0) ? mq[0] : 8'h00;
    if (flush) begin
      mq.delete(); mtrig = 1'b0; tleft = 0;
    end else begin
      req = en && (bk || (sv && chan_mode < 2) || (hw && chan_mode == 2));
      b = bk ? 8'h00 : ((sv && chan_mode < 2) ? sb : hd);
      wasfull = (mq.size() == DEPTH);
      if (rd && en && mq.size() > 0) void'(mq.pop_front());
      if (req && !wasfull) begin mq.push_back(b); acc = 1'b1; end
      if (req && wasfull) exp_ovr = 1'b1;
      n = mq.size();
      if (acc && n >= int'(trig_lvl)) mtrig = 1'b1;
      else if (rd && en && n < int'(trig_lvl)) mtrig = 1'b0;
      if (acc) tleft = 4 * int'(char_clks);
      else if (tleft > 0) begin
        tleft--;
        if (tleft == 0) exp_to = 1'b1;
      end
    end
    check(phase, "st_empty R5", int'(st_empty), int'(mq.size() == 0));
    check(phase, "st_full R4", int'(st_full), int'(mq.size() == DEPTH));
    check(phase, "st_trig R6", int'(st_trig), int'(mtrig));
    check(phase, "ev_overrun R3", int'(ev_overrun), int'(exp_ovr));
    check(phase, "ev_timeout R7", int'(ev_timeout), int'(exp_to));
    if (rd) check(phase, "rd_data R2", int'(rd_data), int'(mrd));
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    cyc(0, 8'h00, 0, 0, 8'h00, 0);
    flush = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R12: reset state
    check("R12", "st_empty", int'(st_empty), 1);
    check("R12", "st_full", int'(st_full), 0);
    check("R12", "st_trig", int'(st_trig), 0);
    check("R12", "ev_overrun", int'(ev_overrun), 0);
    check("R12", "ev_timeout", int'(ev_timeout), 0);
    check("R12", "rd_data", int'(rd_data), 0);

    // R1 R2 R3 R4 R5 R6: threshold sweep, fill past capacity, drain past empty
    phase = "R1";
    for (int t = 0; t <= DEPTH + 2; t++) begin
      trig_lvl = (t == DEPTH + 2) ? 6'd32 : 6'(t);
      do_flush();
      for (int i = 0; i <= DEPTH; i++) cyc(1, 8'(t * 37 + i * 11 + 5), 0, 0, 8'h00, 0);
      for (int i = 0; i <= DEPTH; i++) cyc(0, 8'h00, 0, 0, 8'h00, 1);
    end
    // simultaneous read and offered byte while full
    phase = "R3";
    trig_lvl = 6'd8;
    do_flush();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i + 100), 0, 0, 8'h00, 0);
    cyc(1, 8'hEE, 0, 0, 8'h00, 1);
    for (int i = 0; i <= DEPTH; i++) cyc(0, 8'h00, 0, 0, 8'h00, 1);

    // R10 R11: channel modes crossed with every source mix
    phase = "R10";
    for (int m = 0; m < 4; m++) begin
      chan_mode = 2'(m);
      do_flush();
      for (int mix = 1; mix < 8; mix++) begin
        phase = mix[2] ? "R11" : "R10";
        cyc(mix[0], 8'(m * 16 + mix), mix[2], mix[1], 8'(200 + mix), 0);
      end
      for (int i = 0; i < 9; i++) cyc(0, 8'h00, 0, 0, 8'h00, 1);
    end
    chan_mode = 2'd0;

    // R8: enable and disable combinations
    phase = "R8";
    for (int k = 0; k < 4; k++) begin
      do_flush();
      cyc(1, 8'h11, 0, 0, 8'h00, 0);
      cyc(1, 8'h22, 0, 0, 8'h00, 0);
      rx_en = k[0]; rx_dis = k[1];
      cyc(1, 8'h33, 0, 0, 8'h00, 0);
      cyc(0, 8'h00, 0, 0, 8'h00, 1);
      cyc(0, 8'h00, 1, 0, 8'h00, 0);
      rx_en = 1'b1; rx_dis = 1'b0;
      for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 0, 8'h00, 1);
    end

    // R7: idle timer restarts, dropped byte, disabled timer
    phase = "R7";
    char_clks = 16'd3;
    do_flush();
    cyc(1, 8'h41, 0, 0, 8'h00, 0);
    idle(15);
    cyc(1, 8'h42, 0, 0, 8'h00, 0);
    idle(5);
    cyc(1, 8'h43, 0, 0, 8'h00, 0);
    idle(15);
    do_flush();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i), 0, 0, 8'h00, 0);
    idle(4);
    cyc(1, 8'hAB, 0, 0, 8'h00, 0);
    idle(12);
    char_clks = 16'd0;
    do_flush();
    cyc(1, 8'h44, 0, 0, 8'h00, 0);
    idle(10);
    char_clks = 16'd2;

    // R9: flush priority over push and read, cancels pending timer
    phase = "R9";
    trig_lvl = 6'd4;
    do_flush();
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i + 50), 0, 0, 8'h00, 0);
    flush = 1'b1;
    cyc(1, 8'h77, 0, 0, 8'h00, 1);
    flush = 1'b0;
    idle(12);
    cyc(0, 8'h00, 0, 0, 8'h00, 1);
    cyc(1, 8'h78, 0, 0, 8'h00, 0);
    cyc(0, 8'h00, 0, 0, 8'h00, 1);
    idle(10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule